// File: doc/BRIEF.md
# Interrupt presentation controller

This block sits between one processor and the interrupt source layer. It keeps a 32-bit status word with the processor's current priority in the top byte and the number of the pending source in the low 24 bits. It also keeps the priority of the pending interrupt and a priority register for inter-processor interrupts (IPIs). Lower numbers are more favoured. Each offer from the source layer is either latched or bounced back to the layer through a reject strobe. A more favoured offer displaces the interrupt that is already pending, and that interrupt is rejected back to its source.

The processor drives four commands, each a one-cycle pulse:
- **Set priority** writes the current priority. Lowering it can evict the pending interrupt.
- **Set IPI priority** writes the IPI register and can raise an IPI.
- **Accept** returns the status word and acknowledges the pending interrupt.
- **End-of-interrupt** restores a priority and notifies the source layer.

When the controller can take new work, it asks the source layer to resend bounced interrupts with a one-cycle strobe.

Top module: `irq_presenter`

## Requirements
- R1: After reset the status word is 0 and the pending priority is 0. The IPI priority is 0xFF and `irq_out` is low. The status word holds the current priority in bits 31:24 and the pending source in bits 23:0, and a source of 0 means nothing is pending.
- R2: An offer of priority p is rejected when p is not below the current priority, or when an interrupt is pending whose pending priority is at or below p. `reject_valid` then pulses with the offered source on `reject_src`.
- R3: Any other offer is latched: the previously pending source (if any) is rejected, the new source and p become pending, and `irq_out` rises.
- R4: The IPI priority write always stores the value. When the value is below the current priority, an IPI check runs. The check does nothing if an interrupt is pending at a priority at or below the IPI priority. Otherwise it rejects any pending source, makes source 2 pending at the IPI priority, and raises `irq_out`.
- R5: Writing a current priority below the old one, while a source is pending and the new value is at or below the pending priority, clears the pending source, lowers `irq_out` and rejects that source.
- R6: Writing a current priority that is not below the old one, while nothing is pending, performs a resend.
- R7: A resend runs the IPI check when the IPI priority is below the current priority, and always pulses `resend_req`.
- R8: Accept loads the whole status word into `accept_data`, which is valid in the cycle after the command. It lowers `irq_out` and leaves the status word as the pending priority in the top byte with no source pending.
- R9: End-of-interrupt copies bits 31:24 of the supplied word into the current priority and pulses `eoi_valid` with bits 23:0 on `eoi_src`. If nothing is pending afterwards, it performs a resend.
- R10: All strobes are registered and last one cycle. If several events arrive in one cycle, only the most favoured is acted on and the rest are dropped. The order, most favoured first, is accept, end-of-interrupt, set priority, set IPI priority, offer.
- R11: `irq_out` is high exactly when a source is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| offer_valid | input | 1 | Offer from the source layer |
| offer_src | input | 24 | Offered source number |
| offer_pri | input | 8 | Offered priority |
| cppr_wr | input | 1 | Set current priority command |
| cppr_data | input | 8 | New current priority |
| ipi_wr | input | 1 | Set IPI priority command |
| ipi_data | input | 8 | New IPI priority |
| accept_req | input | 1 | Accept command |
| eoi_wr | input | 1 | End-of-interrupt command |
| eoi_word | input | 32 | Priority to restore and source to notify |
| accept_data | output | 32 | Status word captured by the last accept |
| irq_out | output | 1 | Interrupt line to the processor |
| reject_valid | output | 1 | Reject strobe to the source layer |
| reject_src | output | 24 | Rejected source number |
| resend_req | output | 1 | Resend request to the source layer |
| eoi_valid | output | 1 | End-of-interrupt strobe to the source layer |
| eoi_src | output | 24 | Source for the end-of-interrupt |

## Verification
The bench targets the priority ties. An offer equal to the current priority, or equal to the pending priority, must be rejected; a design using a strict compare there would latch it and raise the line. The bench also exercises displacement: a design that dropped the displaced source instead of rejecting it would lose an interrupt. The bench drives the IPI register below and above the pending priority, so a design that never ran the IPI check would not raise source 2. It also drives the eviction on priority lowering, where a wrong compare leaves a stale source pending. Accept, end-of-interrupt and resend round trips, plus a same-cycle accept and offer, catch a resend that is skipped or misplaced and a broken order between events.

// File: rtl/irqp_pkg.sv
package irqp_pkg;
  localparam int PRI_W  = 8;
  localparam int SRC_W  = 24;
  localparam int WORD_W = PRI_W + SRC_W;
  localparam logic [SRC_W-1:0] IPI_SRC  = 24'd2;
  localparam logic [PRI_W-1:0] PRI_NONE = 8'hFF;

  typedef enum logic [2:0] {
    EV_NONE, EV_ACCEPT, EV_EOI, EV_CPPR, EV_IPI, EV_OFFER
  } event_e;
endpackage

// File: rtl/irqp_offer_eval.sv
module irqp_offer_eval #(
  parameter int PW = 8,
  parameter int SW = 24
) (
  input  logic [PW-1:0] cur_pri,
  input  logic [SW-1:0] pend_src,
  input  logic [PW-1:0] pend_pri,
  input  logic [SW-1:0] new_src,
  input  logic [PW-1:0] new_pri,
  output logic          take,
  output logic          bounce,
  output logic [SW-1:0] bounce_src
);
  logic busy;
  logic lose;
  always_comb begin
    busy = (pend_src != '0);
    lose = (new_pri >= cur_pri) || (busy && (pend_pri <= new_pri));
    take = !lose;
    // A losing offer goes back; a winning one displaces the pending source.
    bounce     = lose || busy;
    bounce_src = lose ? new_src : pend_src;
  end
endmodule

// File: rtl/irqp_ipi_eval.sv
module irqp_ipi_eval #(
  parameter int PW = 8,
  parameter int SW = 24
) (
  input  logic [PW-1:0] ipi_pri,
  input  logic [PW-1:0] cur_pri,
  input  logic [SW-1:0] pend_src,
  input  logic [PW-1:0] pend_pri,
  output logic          hit,
  output logic          load,
  output logic          bounce
);
  logic busy;
  always_comb begin
    busy   = (pend_src != '0);
    hit    = (ipi_pri < cur_pri);
    load   = hit && !(busy && (pend_pri <= ipi_pri));
    bounce = load && busy;
  end
endmodule

// File: rtl/irq_presenter.sv
module irq_presenter
  import irqp_pkg::*;
#(
  parameter int PW = PRI_W,
  parameter int SW = SRC_W,
  parameter logic [SW-1:0] IPI_NUM = IPI_SRC,
  localparam int WW = PW + SW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          offer_valid,
  input  logic [SW-1:0] offer_src,
  input  logic [PW-1:0] offer_pri,
  input  logic          cppr_wr,
  input  logic [PW-1:0] cppr_data,
  input  logic          ipi_wr,
  input  logic [PW-1:0] ipi_data,
  input  logic          accept_req,
  input  logic          eoi_wr,
  input  logic [WW-1:0] eoi_word,
  output logic [WW-1:0] accept_data,
  output logic          irq_out,
  output logic          reject_valid,
  output logic [SW-1:0] reject_src,
  output logic          resend_req,
  output logic          eoi_valid,
  output logic [SW-1:0] eoi_src
);
  localparam logic [PW-1:0] PMAX = {PW{1'b1}};

  logic [PW-1:0] cppr, ppri, mfrr;
  logic [SW-1:0] xisr;

  logic [PW-1:0] n_cppr, n_ppri, n_mfrr;
  logic [SW-1:0] n_xisr, n_rej_src, n_eoi_src;
  logic [WW-1:0] n_acc;
  logic          n_irq, n_rej, n_res, n_eoi;

  event_e ev;
  always_comb begin
    if (accept_req)       ev = EV_ACCEPT;
    else if (eoi_wr)      ev = EV_EOI;
    else if (cppr_wr)     ev = EV_CPPR;
    else if (ipi_wr)      ev = EV_IPI;
    else if (offer_valid) ev = EV_OFFER;
    else                  ev = EV_NONE;
  end

  // Offer decision
  logic          of_take, of_bounce;
  logic [SW-1:0] of_bsrc;
  irqp_offer_eval #(.PW(PW), .SW(SW)) u_offer (
    .cur_pri(cppr), .pend_src(xisr), .pend_pri(ppri),
    .new_src(offer_src), .new_pri(offer_pri),
    .take(of_take), .bounce(of_bounce), .bounce_src(of_bsrc)
  );

  // IPI check, evaluated against the values the command is about to write
  logic [PW-1:0] ck_ipi, ck_cur;
  logic          ck_hit, ck_load, ck_bounce;
  always_comb begin
    ck_ipi = (ev == EV_IPI) ? ipi_data : mfrr;
    case (ev)
      EV_CPPR: ck_cur = cppr_data;
      EV_EOI:  ck_cur = eoi_word[WW-1:SW];
      default: ck_cur = cppr;
    endcase
  end
  irqp_ipi_eval #(.PW(PW), .SW(SW)) u_ipi (
    .ipi_pri(ck_ipi), .cur_pri(ck_cur), .pend_src(xisr), .pend_pri(ppri),
    .hit(ck_hit), .load(ck_load), .bounce(ck_bounce)
  );

  always_comb begin
    n_cppr    = cppr;
    n_ppri    = ppri;
    n_mfrr    = mfrr;
    n_xisr    = xisr;
    n_irq     = irq_out;
    n_acc     = accept_data;
    n_rej     = 1'b0;
    n_rej_src = '0;
    n_res     = 1'b0;
    n_eoi     = 1'b0;
    n_eoi_src = '0;
    case (ev)
      EV_ACCEPT: begin
        n_acc  = {cppr, xisr};
        n_cppr = ppri;
        n_xisr = '0;
        n_irq  = 1'b0;
      end
      EV_EOI: begin
        n_cppr    = eoi_word[WW-1:SW];
        n_eoi     = 1'b1;
        n_eoi_src = eoi_word[SW-1:0];
        if (xisr == '0) begin
          n_res = 1'b1;
          if (ck_load) begin
            n_xisr = IPI_NUM;
            n_ppri = mfrr;
            n_irq  = 1'b1;
          end
        end
      end
      EV_CPPR: begin
        n_cppr = cppr_data;
        if (cppr_data < cppr) begin
          if ((xisr != '0) && (cppr_data <= ppri)) begin
            n_xisr    = '0;
            n_irq     = 1'b0;
            n_rej     = 1'b1;
            n_rej_src = xisr;
          end
        end else if (xisr == '0) begin
          n_res = 1'b1;
          if (ck_load) begin
            n_xisr = IPI_NUM;
            n_ppri = mfrr;
            n_irq  = 1'b1;
          end
        end
      end
      EV_IPI: begin
        n_mfrr = ipi_data;
        if (ck_load) begin
          n_rej     = ck_bounce;
          n_rej_src = ck_bounce ? xisr : '0;
          n_xisr    = IPI_NUM;
          n_ppri    = ipi_data;
          n_irq     = 1'b1;
        end
      end
      EV_OFFER: begin
        n_rej     = of_bounce;
        n_rej_src = of_bounce ? of_bsrc : '0;
        if (of_take) begin
          n_xisr = offer_src;
          n_ppri = offer_pri;
          n_irq  = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cppr         <= '0;
      xisr         <= '0;
      ppri         <= '0;
      mfrr         <= PMAX;
      irq_out      <= 1'b0;
      accept_data  <= '0;
      reject_valid <= 1'b0;
      reject_src   <= '0;
      resend_req   <= 1'b0;
      eoi_valid    <= 1'b0;
      eoi_src      <= '0;
    end else begin
      cppr         <= n_cppr;
      xisr         <= n_xisr;
      ppri         <= n_ppri;
      mfrr         <= n_mfrr;
      irq_out      <= n_irq;
      accept_data  <= n_acc;
      reject_valid <= n_rej;
      reject_src   <= n_rej_src;
      resend_req   <= n_res;
      eoi_valid    <= n_eoi;
      eoi_src      <= n_eoi_src;
    end
  end

  // Assertions
  a_r11_line_tracks_pending: assert property (@(posedge clk) disable iff (rst)
    irq_out == (xisr != '0));

  a_r2_low_offer_bounced: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_OFFER && offer_pri >= cppr) |=>
      (reject_valid && reject_src == $past(offer_src) && $stable(xisr)));

  a_r8_accept_clears: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_ACCEPT) |=> (!irq_out && xisr == '0 && cppr == $past(ppri)));

  a_r9_eoi_strobe: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_EOI) |=> (eoi_valid && eoi_src == $past(eoi_word[SW-1:0])));

  a_r4_ipi_idle_raises: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_IPI && xisr == '0 && ipi_data < cppr) |=>
      (irq_out && xisr == IPI_NUM && !reject_valid));

  a_r10_strobe_single: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_NONE) |=> (!reject_valid && !resend_req && !eoi_valid));

  a_r6_raise_idle_resends: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_CPPR && cppr_data >= cppr && xisr == '0) |=> resend_req);
endmodule

// File: tb/sim_irq_presenter.sv
module sim_irq_presenter;
  logic        clk = 1'b0;
  logic        rst;
  logic        offer_valid, cppr_wr, ipi_wr, accept_req, eoi_wr;
  logic [23:0] offer_src;
  logic [7:0]  offer_pri, cppr_data, ipi_data;
  logic [31:0] eoi_word, accept_data;
  logic        irq_out, reject_valid, resend_req, eoi_valid;
  logic [23:0] reject_src, eoi_src;

  always #5 clk = ~clk;

  irq_presenter u0 (
    .clk(clk), .rst(rst),
    .offer_valid(offer_valid), .offer_src(offer_src), .offer_pri(offer_pri),
    .cppr_wr(cppr_wr), .cppr_data(cppr_data),
    .ipi_wr(ipi_wr), .ipi_data(ipi_data),
    .accept_req(accept_req), .eoi_wr(eoi_wr), .eoi_word(eoi_word),
    .accept_data(accept_data), .irq_out(irq_out),
    .reject_valid(reject_valid), .reject_src(reject_src),
    .resend_req(resend_req), .eoi_valid(eoi_valid), .eoi_src(eoi_src)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  logic [7:0]  m_cppr, m_ppri, m_mfrr;
  logic [23:0] m_xisr;
  logic        e_rej, e_res, e_eoi;
  logic [23:0] e_rsrc, e_esrc;
  logic [31:0] e_acc;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    offer_valid = 0; cppr_wr = 0; ipi_wr = 0; accept_req = 0; eoi_wr = 0;
    offer_src = 0; offer_pri = 0; cppr_data = 0; ipi_data = 0; eoi_word = 0;
  endtask

  // IPI check of the model (R4, R7)
  task automatic m_ipi_check(input logic [7:0] cur);
    if (m_mfrr < cur && !(m_xisr != 0 && m_ppri <= m_mfrr)) begin
      if (m_xisr != 0) begin e_rej = 1; e_rsrc = m_xisr; end
      m_xisr = 24'd2; m_ppri = m_mfrr;
    end
  endtask

  task automatic m_resend();
    m_ipi_check(m_cppr);
    e_res = 1;
  endtask

  // kind: 0 offer, 1 cppr, 2 ipi, 3 accept, 4 eoi
  task automatic model(input int kind, input logic [23:0] a, input logic [7:0] b);
    e_rej = 0; e_res = 0; e_eoi = 0; e_rsrc = 0; e_esrc = 0;
    case (kind)
      0: begin
        if (b >= m_cppr || (m_xisr != 0 && m_ppri <= b)) begin
          e_rej = 1; e_rsrc = a;
        end else begin
          if (m_xisr != 0) begin e_rej = 1; e_rsrc = m_xisr; end
          m_xisr = a; m_ppri = b;
        end
      end
      1: begin
        logic [7:0] old;
        old = m_cppr; m_cppr = b;
        if (b < old) begin
          if (m_xisr != 0 && b <= m_ppri) begin
            e_rej = 1; e_rsrc = m_xisr; m_xisr = 0;
          end
        end else if (m_xisr == 0) m_resend();
      end
      2: begin m_mfrr = b; m_ipi_check(m_cppr); end
      3: begin e_acc = {m_cppr, m_xisr}; m_cppr = m_ppri; m_xisr = 0; end
      default: begin
        m_cppr = b; e_eoi = 1; e_esrc = a;
        if (m_xisr == 0) m_resend();
      end
    endcase
  endtask

  task automatic op(input int kind, input logic [23:0] a, input logic [7:0] b, input string tag);
    @(negedge clk);
    clear_in();
    case (kind)
      0: begin offer_valid = 1; offer_src = a; offer_pri = b; end
      1: begin cppr_wr = 1; cppr_data = b; end
      2: begin ipi_wr = 1; ipi_data = b; end
      3: accept_req = 1;
      default: begin eoi_wr = 1; eoi_word = {b, a}; end
    endcase
    model(kind, a, b);
    @(negedge clk);
    clear_in();
    chk(irq_out == (m_xisr != 0), {tag, " R11 line"}, 64'(irq_out), 64'(m_xisr != 0));
    chk({reject_valid, reject_src} == {e_rej, e_rsrc}, {tag, " reject"},
        64'({reject_valid, reject_src}), 64'({e_rej, e_rsrc}));
    chk(resend_req == e_res, {tag, " R7 resend"}, 64'(resend_req), 64'(e_res));
    chk({eoi_valid, eoi_src} == {e_eoi, e_esrc}, {tag, " R9 eoi"},
        64'({eoi_valid, eoi_src}), 64'({e_eoi, e_esrc}));
    if (kind == 3)
      chk(accept_data == e_acc, {tag, " R8 accept word"}, 64'(accept_data), 64'(e_acc));
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    clear_in();
    rst = 1;
    m_cppr = 0; m_ppri = 0; m_mfrr = 8'hFF; m_xisr = 0; e_acc = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    chk(irq_out == 0, "R1 reset line", 64'(irq_out), 0);
    op(3, 0, 0, "R1 reset word");
    // R6: raise priority with nothing pending; IPI FF gives no IPI (R1)
    op(1, 0, 8'hFF, "R6 raise idle");
    op(0, 24'd20, 8'd5, "R3 first offer");
    op(0, 24'd21, 8'd5, "R2 tie pending");
    op(0, 24'd22, 8'd3, "R3 displace");
    op(0, 24'd23, 8'hFF, "R2 tie current");
    op(2, 0, 8'd3, "R4 ipi tie");
    op(2, 0, 8'd1, "R4 ipi preempt");
    op(3, 0, 0, "R8 accept ipi");
    op(4, 24'd2, 8'hFF, "R9 eoi resend ipi");
    op(1, 0, 8'd0, "R5 evict");
    op(1, 0, 8'd0, "R6 equal idle");
    // R10: one-cycle strobes, idle cycle shows none
    @(negedge clk);
    chk(!reject_valid && !resend_req && !eoi_valid, "R10 idle strobes",
        64'({reject_valid, resend_req, eoi_valid}), 0);
    op(1, 0, 8'd10, "R6 raise");
    op(0, 24'd30, 8'd6, "R3 offer");
    // R10: accept and offer together, offer dropped
    @(negedge clk);
    clear_in();
    accept_req = 1; offer_valid = 1; offer_src = 24'd31; offer_pri = 8'd0;
    model(3, 0, 0);
    @(negedge clk);
    clear_in();
    chk(!reject_valid && !irq_out, "R10 precedence drop",
        64'({reject_valid, irq_out}), 0);
    chk(accept_data == e_acc, "R10 precedence accept", 64'(accept_data), 64'(e_acc));
    // random mix
    void'($urandom(32'd1234));
    for (int i = 0; i < 600; i++) begin
      int k;
      logic [7:0] p;
      logic [23:0] s;
      k = $urandom_range(0, 4);
      p = ($urandom_range(0, 9) == 0) ? 8'hFF : 8'($urandom_range(0, 12));
      s = 24'($urandom_range(16, 47));
      if (k == 4) s = m_xisr == 0 ? s : m_xisr;
      op(k, s, p, "R2 R3 R4 R5 R9 random");
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule